// File: doc/BRIEF.md
# Configuration Word Checksum Checker

The block checks the integrity of a block of configuration words as they stream past. Words arrive one per accepted transfer on a valid/ready input, and the final word of each block is flagged as last. Every word before the final one is added into a wide accumulator. The final word is the stored checksum and is compared against the sum without being added to it. One cycle after the final word is accepted, the block raises a one-cycle result strobe with a pass flag.

A block is rejected when its whole accumulated sum is zero. This covers an erased or blank image, and it also covers a block that holds only the checksum word. Otherwise the block passes only when the low word-width bits of the sum match the stored checksum. Carries above those bits take part in the zero test but not in the comparison.

Back-pressure works as follows. A word transfers on a rising edge where `in_valid` and `in_ready` are both high. The source must hold `in_data` and `in_last` stable while `in_valid` is high and `in_ready` is low. `in_ready` drops for exactly the cycle in which the result is presented, so the next block starts with a one-cycle bubble. There is no back-pressure on the result, and the consumer must take it in the strobe cycle.

Top module: `cfg_cksum_chk`

## Requirements
- R1: After reset, `res_valid` and `res_pass` are 0 and `in_ready` is 1.
- R2: Every accepted word whose `in_last` is 0 is added, zero-extended, into an accumulator of ACC_W bits (default 32) that wraps modulo 2^ACC_W. Carries out of bit 15 are therefore kept.
- R3: The accepted word with `in_last` = 1 is taken as the stored checksum and is not added to the sum.
- R4: If the accumulated sum is zero when the checksum word is accepted, the result is fail (`res_pass` = 0).
- R5: If the sum is non-zero, the result is pass exactly when sum bits [15:0] equal the checksum word. For example, data 0x8000, 0x8000 with checksum 0x0000 passes.
- R6: `res_valid` is 1 in the cycle after the checksum word is accepted and only then, for one cycle. `res_pass` is 0 whenever `res_valid` is 0.
- R7: `in_ready` is 0 in the result cycle. A word offered in that cycle is not accepted and has no effect on any result.
- R8: The accumulator is cleared when the checksum word is accepted, so each block's result depends only on that block's words.
- R9: A block consisting of a single word (with `in_last` = 1) has a zero sum and fails, whatever its value.
- R10: Cycles with `in_valid` = 0 leave the sum unchanged, so idle gaps inside a block do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be accepted this cycle |
| in_data | input | DATA_W (16) | Configuration word, or the stored checksum when last |
| in_last | input | 1 | Marks the final (checksum) word of a block |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Block checksum correct (meaningful with res_valid) |

## Verification
The bench builds the block with its defaults: 16-bit words and a 32-bit accumulator. Because the accumulator is twice the word width, sums that carry past bit 15 are reachable with only two or three words. This separates the full-sum zero test from the low-bits comparison, and it exposes any narrowing of the accumulator. A behavioural model follows the handshake every cycle, and targeted blocks exercise the single-word case, a zero-sum block, a word offered during the result bubble, idle gaps and blocks sent back to back.

// File: rtl/cks_pkg.sv
package cks_pkg;
  // What the accumulator does with the word transferred this cycle
  typedef enum logic [1:0] {
    W_NONE  = 2'd0,
    W_ADD   = 2'd1,
    W_FINAL = 2'd2
  } word_kind_e;
endpackage

// File: rtl/cks_accum.sv
module cks_accum
  import cks_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  word_kind_e        kind,
  input  logic [DATA_W-1:0] data,
  output logic [ACC_W-1:0]  acc
);
  localparam int PAD_W = ACC_W - DATA_W;

  logic [ACC_W-1:0] data_ext;
  assign data_ext = {{PAD_W{1'b0}}, data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else begin
      unique case (kind)
        W_ADD:   acc <= acc + data_ext;
        W_FINAL: acc <= '0;
        default: acc <= acc;
      endcase
    end
  end

  // R8: the checksum word leaves an empty accumulator behind it
  a_r8_cleared_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == W_FINAL) |=> (acc == '0));

  // R10: no transfer, no change
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == W_NONE) |=> $stable(acc));
endmodule

// File: rtl/cks_judge.sv
module cks_judge
  import cks_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  word_kind_e        kind,
  input  logic [DATA_W-1:0] data,
  input  logic [ACC_W-1:0]  acc,
  output logic              res_valid,
  output logic              res_pass
);
  logic sum_nonzero;
  logic low_match;
  logic verdict;

  assign sum_nonzero = |acc;
  assign low_match   = (acc[DATA_W-1:0] == data);
  assign verdict     = sum_nonzero && low_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
    end else begin
      res_valid <= (kind == W_FINAL);
      res_pass  <= (kind == W_FINAL) && verdict;
    end
  end

  // R4: a reported pass never comes from an all-zero sum
  a_r4_zero_never_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass) |-> ($past(acc) != '0));

  // R6: pass is only raised together with the strobe
  a_r6_pass_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    res_pass |-> res_valid);
endmodule

// File: rtl/cfg_cksum_chk.sv
module cfg_cksum_chk
  import cks_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              res_valid,
  output logic              res_pass
);
  logic             xfer;
  word_kind_e       kind;
  logic [ACC_W-1:0] acc;

  // The result cycle is a one-cycle bubble on the input
  assign in_ready = !res_valid;
  assign xfer     = in_valid && in_ready;

  always_comb begin
    if (!xfer)        kind = W_NONE;
    else if (in_last) kind = W_FINAL;
    else              kind = W_ADD;
  end

  cks_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .kind  (kind),
    .data  (in_data),
    .acc   (acc)
  );

  cks_judge #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (kind),
    .data      (in_data),
    .acc       (acc),
    .res_valid (res_valid),
    .res_pass  (res_pass)
  );

  // R6: accepted checksum word is followed by the strobe
  a_r6_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> res_valid);

  // R6: strobe lasts one cycle
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7: a word offered in the result cycle leaves the sum empty
  a_r7_bubble_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (acc == '0));
endmodule

// File: tb/cfg_cksum_chk_test.sv
module cfg_cksum_chk_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_last = 1'b0;
  logic          res_valid;
  logic          res_pass;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  cfg_cksum_chk #(.DATA_W(DW), .ACC_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .res_valid(res_valid), .res_pass(res_pass)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: plain integer sum, updated at each edge
  longint m_sum = 0;
  bit     m_rv = 0;
  bit     m_pass = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sum = 0; m_rv = 0; m_pass = 0;
    end else begin
      bit fire;
      fire = in_valid && !m_rv;
      if (fire && in_last) begin
        m_pass = (m_sum != 0) && ((m_sum & 64'hFFFF) == longint'(in_data));
        m_rv = 1;
        m_sum = 0;
      end else begin
        if (fire) m_sum = (m_sum + longint'(in_data)) & 64'hFFFF_FFFF;
        m_rv = 0;
        m_pass = 0;
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(res_valid, m_rv, "R6 strobe vs model");
      check(res_pass, m_pass, "R5 pass vs model");
      check(in_ready, !m_rv, "R7 ready vs model");
    end
  end

  // Called at a negedge; returns at the negedge after the word transfers
  task automatic put(input logic [DW-1:0] d, input logic l);
    in_valid = 1'b1; in_data = d; in_last = l;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_result(input logic exp_pass, input string tag);
    check(res_valid, 1'b1, {tag, " strobe"});
    check(res_pass, exp_pass, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(res_valid, 1'b0, "R1 res_valid in reset");
    check(res_pass, 1'b0, "R1 res_pass in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready, 1'b1, "R1 in_ready after reset");
    check(res_valid, 1'b0, "R1 res_valid after reset");

    // R2 R5: simple sum matches
    put(16'd1, 0); put(16'd2, 0); put(16'd3, 0); put(16'd6, 1);
    expect_result(1'b1, "R2 R5 sum 6 checksum 6");
    idle(1);
    check(res_valid, 1'b0, "R6 strobe one cycle");

    // R5 mismatch
    put(16'd1, 0); put(16'd2, 0); put(16'd3, 0); put(16'd7, 1);
    expect_result(1'b0, "R5 sum 6 checksum 7");
    idle(1);

    // R3: checksum word not added
    put(16'h1234, 0); put(16'h1234, 1);
    expect_result(1'b1, "R3 last word excluded");
    idle(2);

    // R4: zero sum fails even with matching checksum
    put(16'h0, 0); put(16'h0, 0); put(16'h0, 0); put(16'h0, 1);
    expect_result(1'b0, "R4 zero sum");
    idle(1);

    // R2 R5: carry beyond bit 15 kept, compare on low bits
    put(16'h8000, 0); put(16'h8000, 0); put(16'h0000, 1);
    expect_result(1'b1, "R2 R5 carry sum 0x10000");
    idle(1);
    put(16'hFFFF, 0); put(16'h0003, 0); put(16'h0002, 1);
    expect_result(1'b1, "R5 wrap low bits 0x0002");
    idle(1);

    // R9: single-word blocks
    put(16'h0000, 1);
    expect_result(1'b0, "R9 single word zero");
    idle(1);
    put(16'h0055, 1);
    expect_result(1'b0, "R9 single word 0x55");

    // R7: word offered in the result cycle is refused
    check(in_ready, 1'b0, "R7 ready low in result cycle");
    in_valid = 1'b1; in_data = 16'h7777; in_last = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    put(16'h0100, 0); put(16'h0200, 0); put(16'h0300, 1);
    expect_result(1'b1, "R7 bubble word ignored");

    // R8: back-to-back block, accumulator cleared
    put(16'h0007, 0); put(16'h0007, 1);
    expect_result(1'b1, "R8 fresh sum after result");
    idle(1);

    // R10: idle gaps inside a block
    put(16'h000A, 0); idle(3); put(16'h000B, 0); idle(2); put(16'h0015, 1);
    expect_result(1'b1, "R10 gaps in block");
    idle(1);

    // R2: longer block, bench-computed checksum
    begin
      int s = 0;
      for (int i = 1; i <= 40; i++) begin
        put(DW'(i * 16'h0101), 0);
        s += i * 16'h0101;
      end
      put(DW'(s), 1);
      expect_result(1'b1, "R2 forty-word block");
      idle(1);
    end

    // R2: narrowing accumulator would zero this sum
    put(16'hFFFF, 0); put(16'h0001, 0); put(16'h0000, 1);
    expect_result(1'b1, "R2 sum 0x10000 nonzero");
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule